// File: doc/BRIEF.md
# Base-Index-Displacement Address Generator

This block forms the effective storage address of one instruction operand. It takes two 4-bit register selectors (base and index) and a 12-bit displacement. It reads the selected entries of a 16 x 32-bit general register file, adds them, and then cuts the sum down to the width chosen by a run-time addressing-mode bit. A separate write port loads the register file.

A register selector of zero does not read register 0. It means "no term", so that term adds zero. When register-direct addressing is chosen, the register named by the base selector supplies the whole intermediate value. The index term can also be switched off for instruction formats that have no index field.

Each request produces a registered result one clock later, together with a single-cycle valid pulse. A register write in the same cycle as a request is seen only by later requests.

Top module: `bxd_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `addrValid` is 0 and `effAddr` is 0 until the first request is served.
- R2: A base or index selector of value 0 contributes zero to the sum, whatever register 0 holds.
- R3: The displacement is unsigned. It is zero-extended with 20 zero bits, so 0xFFF adds 4095 and 0 adds nothing.
- R4: Base, index and extended displacement are added modulo 2^32, and the carry out of the top bit is discarded.
- R5: With `wideMode` = 0 (24-bit mode), `effAddr[23:0]` equals the low 24 bits of the intermediate value and `effAddr[31:24]` is 0.
- R6: With `wideMode` = 1 (31-bit mode), `effAddr[30:0]` equals the low 31 bits of the intermediate value and `effAddr[31]` is 0.
- R7: With `directMode` = 1, the intermediate value is the full contents of the register named by `baseSel`, register 0 included. Index and displacement are ignored, and the R5/R6 truncation still applies.
- R8: With `indexEn` = 0, the index term is zero whatever `indexSel` names.
- R9: The result is on `effAddr` one clock after `reqValid` is sampled high, and `addrValid` is high for exactly that one cycle. Without a request, `effAddr` holds its last value.
- R10: A register write sampled in the same cycle as a request does not affect that request's result. It does affect every later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe: compute an address this cycle |
| baseSel | input | 4 | Base register number (0 = no base); the register in direct mode |
| indexSel | input | 4 | Index register number (0 = no index) |
| indexEn | input | 1 | 1 = format carries an index field |
| disp | input | 12 | Unsigned displacement |
| wideMode | input | 1 | 0 = 24-bit, 1 = 31-bit addressing |
| directMode | input | 1 | 1 = register-direct addressing |
| wrEn | input | 1 | Register file write enable |
| wrSel | input | 4 | Register number to write |
| wrData | input | 32 | Data to write |
| effAddr | output | 32 | Registered effective address |
| addrValid | output | 1 | One-cycle strobe marking a new `effAddr` |

## Verification
A register write and an address request can land in the same clock edge, and the write may target the very register the request reads as base or index. The bench provokes this collision on purpose. It expects the request to return the sum built from the value held before the write, and it expects the following request to see the new value. The random phase also mixes writes with requests in the same cycle. The bench reference model always computes the expected address from its register shadow before it applies the write to that shadow.

// File: rtl/bxd_agen_pkg.sv
package bxd_agen_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned REG_CNT  = 16;
  localparam int unsigned SEL_W    = $clog2(REG_CNT);
  localparam int unsigned DISP_W   = 12;
  localparam int unsigned NARROW_W = 24;
  localparam int unsigned WIDE_W   = 31;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic capture;     // load the result register this edge
    logic useDirect;   // register-direct intermediate value
    logic useIndex;    // index term enabled by format
    logic keepWide;    // 31-bit truncation instead of 24-bit
  } agenStrobe_t;
endpackage

// File: rtl/bxd_agen_regfile.sv
module bxd_agen_regfile #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_CNT = 16,
  localparam int unsigned SEL_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSelA,
  input  logic [SEL_W-1:0]  rdSelB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [DATA_W-1:0] regArray [REG_CNT];

  always_ff @(posedge clk) begin
    if (wrEn) regArray[wrSel] <= wrData;
  end

  // Reads see the stored value; a write this cycle lands at the edge
  assign rdDataA = regArray[rdSelA];
  assign rdDataB = regArray[rdSelB];
endmodule

// File: rtl/bxd_agen_ctrl.sv
module bxd_agen_ctrl
  import bxd_agen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        indexEn,
  input  logic        wideMode,
  input  logic        directMode,
  output agenStrobe_t strobe,
  output logic        resultValid
);
  always_comb begin
    strobe.capture   = reqValid;
    strobe.useDirect = directMode;
    strobe.useIndex  = indexEn & ~directMode;
    strobe.keepWide  = wideMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= reqValid;
  end
endmodule

// File: rtl/bxd_agen_datapath.sv
module bxd_agen_datapath
  import bxd_agen_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned REG_CNT  = 16,
  parameter int unsigned DISP_W   = 12,
  parameter int unsigned NARROW_W = 24,
  parameter int unsigned WIDE_W   = 31,
  localparam int unsigned SEL_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  agenStrobe_t       strobe,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [SEL_W-1:0]  indexSel,
  input  logic [DISP_W-1:0] disp,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] effAddr
);
  logic [DATA_W-1:0] baseRaw, indexRaw;
  logic [DATA_W-1:0] baseTerm, indexTerm, dispTerm;
  logic [DATA_W-1:0] sumValue, interValue;
  logic [DATA_W-1:0] narrowAddr, wideAddr, nextAddr;

  bxd_agen_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_regs (
    .clk(clk), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSelA(baseSel), .rdSelB(indexSel),
    .rdDataA(baseRaw), .rdDataB(indexRaw)
  );

  // Selector zero means the term is absent
  assign baseTerm  = (baseSel == '0) ? '0 : baseRaw;
  assign indexTerm = (strobe.useIndex && indexSel != '0) ? indexRaw : '0;
  assign dispTerm  = {{(DATA_W-DISP_W){1'b0}}, disp};

  assign sumValue   = baseTerm + indexTerm + dispTerm;
  assign interValue = strobe.useDirect ? baseRaw : sumValue;

  // Per-bit truncation masks
  for (genvar b = 0; b < DATA_W; b++) begin : g_trunc
    if (b < NARROW_W) begin : g_keepN
      assign narrowAddr[b] = interValue[b];
    end else begin : g_zeroN
      assign narrowAddr[b] = 1'b0;
    end
    if (b < WIDE_W) begin : g_keepW
      assign wideAddr[b] = interValue[b];
    end else begin : g_zeroW
      assign wideAddr[b] = 1'b0;
    end
  end

  assign nextAddr = strobe.keepWide ? wideAddr : narrowAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               effAddr <= '0;
    else if (strobe.capture) effAddr <= nextAddr;
  end

  // R2
  no_base_no_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.useDirect && baseSel == '0 && indexSel == '0)
      |=> (effAddr == {{(DATA_W-DISP_W){1'b0}}, $past(disp)}));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(effAddr));
endmodule

// File: rtl/bxd_addr_gen.sv
module bxd_addr_gen
  import bxd_agen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [3:0]  baseSel,
  input  logic [3:0]  indexSel,
  input  logic        indexEn,
  input  logic [11:0] disp,
  input  logic        wideMode,
  input  logic        directMode,
  input  logic        wrEn,
  input  logic [3:0]  wrSel,
  input  logic [31:0] wrData,
  output logic [31:0] effAddr,
  output logic        addrValid
);
  agenStrobe_t strobe;

  bxd_agen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .indexEn(indexEn),
    .wideMode(wideMode), .directMode(directMode),
    .strobe(strobe), .resultValid(addrValid)
  );

  bxd_agen_datapath #(
    .DATA_W(DATA_W), .REG_CNT(REG_CNT), .DISP_W(DISP_W),
    .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .baseSel(baseSel), .indexSel(indexSel), .disp(disp),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .effAddr(effAddr)
  );

  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid);

  // R9
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid);

  // R5
  narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !wideMode) |=> (effAddr[31:24] == 8'h00));

  // R6
  wide_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && wideMode) |=> !effAddr[31]);
endmodule

// File: tb/bxd_addr_gen_tb.sv
`timescale 1ns/1ps
module bxd_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  baseSel = '0, indexSel = '0, wrSel = '0;
  logic        indexEn = 1'b0, wideMode = 1'b0, directMode = 1'b0, wrEn = 1'b0;
  logic [11:0] disp = '0;
  logic [31:0] wrData = '0;
  logic [31:0] effAddr;
  logic        addrValid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] shadow [16];

  always #10 clk = ~clk;

  bxd_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .baseSel(baseSel),
    .indexSel(indexSel), .indexEn(indexEn), .disp(disp), .wideMode(wideMode),
    .directMode(directMode), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .effAddr(effAddr), .addrValid(addrValid)
  );

  function automatic logic [31:0] refAddr(input logic [3:0] b, input logic [3:0] x,
      input logic xe, input logic [11:0] d, input logic wide, input logic direct);
    logic [31:0] inter;
    if (direct) inter = shadow[b];
    else inter = ((b == 0) ? 32'h0 : shadow[b]) + ((xe && x != 0) ? shadow[x] : 32'h0)
                 + {20'h0, d};
    return wide ? {1'b0, inter[30:0]} : {8'h00, inter[23:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] sel, input logic [31:0] val);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
    shadow[sel] = val;
  endtask

  // Issue request at a negedge, check one edge later
  task automatic request(input string req, input logic [3:0] b, input logic [3:0] x,
      input logic xe, input logic [11:0] d, input logic wide, input logic direct);
    logic [31:0] exp;
    baseSel = b; indexSel = x; indexEn = xe; disp = d;
    wideMode = wide; directMode = direct; reqValid = 1'b1;
    exp = refAddr(b, x, xe, d, wide, direct);
    @(negedge clk);
    reqValid = 1'b0;
    if (wrEn) begin shadow[wrSel] = wrData; wrEn = 1'b0; end
    check(req, effAddr, exp);
    check("R9 valid", {31'h0, addrValid}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset addr", effAddr, 32'h0);
    check("R1 reset valid", {31'h0, addrValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release addr", effAddr, 32'h0);
    check("R1 after release valid", {31'h0, addrValid}, 32'h0);

    for (int i = 0; i < 16; i++) writeReg(i[3:0], 32'h1000_0000 * i + 32'h0101 * i);
    writeReg(4'd0, 32'hDEAD_BEEF);
    writeReg(4'd1, 32'hFFFF_FFFF);
    writeReg(4'd2, 32'h0000_0002);
    writeReg(4'd3, 32'hABCD_EF12);

    // R2: zero selectors ignore register 0
    request("R2 both absent", 4'd0, 4'd0, 1'b1, 12'h123, 1'b1, 1'b0);
    check("R2 value", effAddr, 32'h0000_0123);
    request("R2 base absent", 4'd0, 4'd5, 1'b1, 12'h010, 1'b1, 1'b0);
    // R3: displacement not sign-extended
    request("R3 max disp", 4'd0, 4'd0, 1'b0, 12'hFFF, 1'b1, 1'b0);
    check("R3 value", effAddr, 32'h0000_0FFF);
    request("R3 zero disp", 4'd3, 4'd0, 1'b0, 12'h000, 1'b1, 1'b0);
    // R4: carry dropped
    request("R4 wrap", 4'd1, 4'd2, 1'b1, 12'h000, 1'b1, 1'b0);
    check("R4 value", effAddr, 32'h0000_0001);
    // R5 / R6 truncation
    request("R5 narrow", 4'd3, 4'd0, 1'b0, 12'h010, 1'b0, 1'b0);
    check("R5 value", effAddr, 32'h00CD_EF22);
    request("R6 wide", 4'd3, 4'd0, 1'b0, 12'h010, 1'b1, 1'b0);
    check("R6 value", effAddr, 32'h2BCD_EF22);
    // R7 direct mode, register 0 allowed
    request("R7 direct r0", 4'd0, 4'd3, 1'b1, 12'hFFF, 1'b1, 1'b0 | 1'b1);
    check("R7 value", effAddr, 32'h5EAD_BEEF);
    request("R7 direct narrow", 4'd3, 4'd1, 1'b1, 12'h777, 1'b0, 1'b1);
    check("R7 narrow value", effAddr, 32'h00CD_EF12);
    // R8 index disabled
    request("R8 no index", 4'd2, 4'd1, 1'b0, 12'h004, 1'b1, 1'b0);
    check("R8 value", effAddr, 32'h0000_0006);

    // R9: idle cycle holds address and drops valid
    held = effAddr;
    @(negedge clk);
    check("R9 idle valid", {31'h0, addrValid}, 32'h0);
    check("R9 held addr", effAddr, held);

    // R10: write to the base register in the request cycle
    wrEn = 1'b1; wrSel = 4'd2; wrData = 32'h0000_5000;
    request("R10 old value", 4'd2, 4'd0, 1'b0, 12'h001, 1'b1, 1'b0);
    check("R10 old sum", effAddr, 32'h0000_0003);
    request("R10 new value", 4'd2, 4'd0, 1'b0, 12'h001, 1'b1, 1'b0);
    check("R10 new sum", effAddr, 32'h0000_5001);

    // Constrained random mix (R4 general sum), with same-cycle writes
    for (int n = 0; n < 400; n++) begin
      logic [31:0] v;
      case ($urandom_range(0, 3))
        0: v = 32'hFFFF_FFFF - $urandom_range(0, 4095);
        1: v = $urandom_range(0, 4095);
        default: v = $urandom;
      endcase
      if ($urandom_range(0, 2) == 0) begin
        wrEn = 1'b1; wrSel = 4'($urandom_range(0, 15)); wrData = v;
      end
      request("R4 random", 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
              1'($urandom_range(0, 1)), 12'($urandom_range(0, 4095)),
              1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0));
      if ($urandom_range(0, 3) == 0) begin
        held = effAddr;
        @(negedge clk);
        check("R9 random idle", {31'h0, addrValid} | (effAddr ^ held), 32'h0);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule